// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands in the execute stage of a five-stage pipeline, where the operand value should come from. There are three candidate sources: the register file read that was captured at decode, the ALU result that sits one stage ahead in the memory-stage register, and the value about to be written back that sits two stages ahead. The block compares each operand's source register number with the destination register number of each older instruction. A comparison only counts when that instruction actually writes a register.

The outputs are plain 2-bit select codes that drive the operand multiplexers. Those multiplexers are outside this block, and so is load-use stall detection. The logic is purely combinational. A select settles in the same cycle as the register numbers and write enables that produce it.

A back-to-back chain of dependents can run without bubbles. This is the case where one instruction writes a register and the next several each read it. The first reader takes the memory-stage result. The second takes the writeback value. Later readers see the updated register file.

Top module: `operand_bypass_sel`

## Requirements
- R1: When no qualifying match exists for an operand, its select is 2'b00 (register file value).
- R2: When the memory-stage instruction has its write enable at 1, writes a nonzero register, and that register equals the operand's source register, the select is 2'b10.
- R3: When only the writeback-stage instruction qualifies and matches the operand's source register, the select is 2'b01.
- R4: When both older stages qualify and match the same operand, the memory-stage source wins and the select is 2'b10.
- R5: A destination of register 0 never causes forwarding, whatever the write enables are.
- R6: A stage whose write enable is 0 has no effect on either select, even when its destination matches.
- R7: The two operand selects are independent: the Rs-side select depends only on the Rs number and the stage fields, and the Rt-side select depends only on the Rt number and the stage fields.
- R8: Consider an instruction that writes register r followed by consecutive readers of r. The first reader selects 2'b10, the second selects 2'b01, and the third and later readers select 2'b00.
- R9: The code 2'b11 never appears on either select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register number of the instruction in execute |
| ex_rt | input | 5 | Second source register number of the instruction in execute |
| mem_rd | input | 5 | Destination register number held in the memory-stage register |
| mem_wen | input | 1 | Register write enable of the memory-stage instruction |
| wb_rd | input | 5 | Destination register number held in the writeback-stage register |
| wb_wen | input | 1 | Register write enable of the writeback-stage instruction |
| fwd_a | output | 2 | Select for the first ALU operand: 00 register file, 10 memory stage, 01 writeback |
| fwd_b | output | 2 | Select for the second ALU operand, same encoding |

## Verification
The block holds no state, so any wrong comparison or a wrong priority order shows up on fwd_a or fwd_b in the same cycle as the offending inputs. None of it is hidden for later cycles. Three faults are the hardest to see because each one only shows for particular register patterns: a dropped check of register 0, a dropped write-enable qualifier, and a swapped priority. The bench therefore sweeps register numbers that include 0, matching values and non-matching values, under all four write-enable pairs. It also replays the dependent chain cycle by cycle.

// File: rtl/obs_pkg.sv
package obs_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_MEMSTG  = 2'b10
    } src_sel_e;

    localparam int NUM_OPERANDS = 2;

endpackage

// File: rtl/obs_hit.sv
module obs_hit #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] op_reg,
    input  logic [REG_W-1:0] dst_reg,
    input  logic             dst_wen,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic dst_live;

    always_comb begin
        dst_live = dst_wen && (dst_reg != ZERO_REG);
        hit      = dst_live && (dst_reg == op_reg);
    end

    // R5: a hit is impossible on the hard-wired zero register
    always_comb begin
        if (op_reg == ZERO_REG)
            p_zero_never_hits_r5: assert (!hit);
    end

endmodule

// File: rtl/obs_pick.sv
module obs_pick
    import obs_pkg::*;
(
    input  logic     hit_mem,
    input  logic     hit_wb,
    output src_sel_e sel
);
    always_comb begin
        unique case ({hit_mem, hit_wb})
            2'b10, 2'b11: sel = SRC_MEMSTG;
            2'b01:        sel = SRC_WBACK;
            default:      sel = SRC_REGFILE;
        endcase
    end

    // R4: newer memory-stage value always wins
    always_comb begin
        if (hit_mem)
            p_mem_wins_r4: assert (sel == SRC_MEMSTG);
    end

endmodule

// File: rtl/operand_bypass_sel.sv
module operand_bypass_sel
    import obs_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ex_rs,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b
);
    logic [NUM_OPERANDS-1:0][REG_W-1:0] op_regs;
    logic [NUM_OPERANDS-1:0]            hit_mem;
    logic [NUM_OPERANDS-1:0]            hit_wb;
    logic [NUM_OPERANDS-1:0][1:0]       op_sel;

    assign op_regs[0] = ex_rs;
    assign op_regs[1] = ex_rt;

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_operand
        src_sel_e sel_e;

        obs_hit #(.REG_W(REG_W)) u_hit_mem (
            .op_reg  (op_regs[g]),
            .dst_reg (mem_rd),
            .dst_wen (mem_wen),
            .hit     (hit_mem[g])
        );

        obs_hit #(.REG_W(REG_W)) u_hit_wb (
            .op_reg  (op_regs[g]),
            .dst_reg (wb_rd),
            .dst_wen (wb_wen),
            .hit     (hit_wb[g])
        );

        obs_pick u_pick (
            .hit_mem (hit_mem[g]),
            .hit_wb  (hit_wb[g]),
            .sel     (sel_e)
        );

        assign op_sel[g] = sel_e;
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    always_comb begin
        p_no_illegal_code_a_r9: assert (fwd_a != 2'b11);
        p_no_illegal_code_b_r9: assert (fwd_b != 2'b11);
        if (!mem_wen && !wb_wen) begin
            p_disabled_stages_a_r6: assert (fwd_a == 2'b00);
            p_disabled_stages_b_r6: assert (fwd_b == 2'b00);
        end
        if (mem_wen && (mem_rd != '0) && (mem_rd == ex_rt))
            p_mem_hit_b_r2: assert (fwd_b == 2'b10);
        if (fwd_a == 2'b01)
            p_wb_only_a_r3: assert (wb_wen && (wb_rd == ex_rs) && (wb_rd != '0));
    end

endmodule

// File: tb/operand_bypass_sel_bench.sv
module operand_bypass_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W = 5;

    logic clk = 1'b0;
    logic [REG_W-1:0] ex_rs, ex_rt, mem_rd, wb_rd;
    logic mem_wen, wb_wen;
    logic [1:0] fwd_a, fwd_b;
    int total = 0;
    int bad = 0;
    logic [REG_W-1:0] pool [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    operand_bypass_sel #(.REG_W(REG_W)) u_operand_bypass_sel (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    function automatic logic [1:0] model(logic [REG_W-1:0] src);
        logic m, w;
        m = mem_wen && (mem_rd != 0) && (mem_rd == src);
        w = wb_wen && (wb_rd != 0) && (wb_rd == src);
        if (m) return 2'b10;
        if (w) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string tag_for(logic [REG_W-1:0] src);
        logic mm, wm;
        mm = (mem_rd == src);
        wm = (wb_rd == src);
        if ((mm && mem_rd == 0) || (wm && wb_rd == 0)) return "R5";
        if ((mm && !mem_wen) || (wm && !wb_wen)) return "R6";
        if (mm && wm) return "R4";
        if (mm) return "R2";
        if (wm) return "R3";
        return "R1";
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b (rs=%0d rt=%0d mrd=%0d mw=%b wrd=%0d ww=%b)",
                     req, act, exp, ex_rs, ex_rt, mem_rd, mem_wen, wb_rd, wb_wen);
        end
    endtask

    task automatic drive(logic [REG_W-1:0] rs, logic [REG_W-1:0] rt,
                         logic [REG_W-1:0] mrd, logic mw,
                         logic [REG_W-1:0] wrd, logic ww);
        @(negedge clk);
        ex_rs = rs; ex_rt = rt; mem_rd = mrd; mem_wen = mw; wb_rd = wrd; wb_wen = ww;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [1:0] held;
        pool[0] = 5'd0; pool[1] = 5'd1; pool[2] = 5'd7; pool[3] = 5'd31;

        // R1: idle inputs give the register file select
        drive(0, 0, 0, 0, 0, 0);
        check("R1 idle a", fwd_a, 2'b00);
        check("R1 idle b", fwd_b, 2'b00);

        // sweep covering R1..R6 and R9
        for (int en = 0; en < 4; en++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int k = 0; k < 4; k++)
                        for (int l = 0; l < 4; l++) begin
                            drive(pool[i], pool[j], pool[k], en[1], pool[l], en[0]);
                            check(tag_for(ex_rs), fwd_a, model(ex_rs));
                            check(tag_for(ex_rt), fwd_b, model(ex_rt));
                            check("R9", {1'b0, fwd_a == 2'b11 || fwd_b == 2'b11}, 2'b00);
                        end

        // R7: rt select unchanged while rs varies
        drive(3, 9, 9, 1, 3, 1);
        held = fwd_b;
        check("R7 base b", fwd_b, 2'b10);
        for (int v = 0; v < 32; v++) begin
            drive(v[REG_W-1:0], 9, 9, 1, 3, 1);
            check("R7 b stable", fwd_b, held);
            check("R7 a tracks", fwd_a, model(ex_rs));
        end

        // R8: producer writes r1, readers follow back to back
        drive(1, 3, 1, 1, 0, 0);
        check("R8 first reader", fwd_a, 2'b10);
        drive(1, 7, 4, 1, 1, 1);
        check("R8 second reader", fwd_a, 2'b01);
        drive(8, 1, 6, 1, 4, 1);
        check("R8 third reader", fwd_b, 2'b00);
        drive(1, 11, 8, 1, 6, 1);
        check("R8 fourth reader", fwd_a, 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule